// File: doc/BRIEF.md
# Chip-Select Controller for Asynchronous Memories

This block sits between an internal bus master and a set of simple asynchronous devices such as SRAM, EPROM and flash. When the master presents an access, the block compares its address against twelve independently configured regions. It raises the chip-select of the winning region, and it drives the read strobe or the byte write strobes. The strobes stay up for that region's programmed number of wait cycles, and the block then returns a single-cycle acknowledge. An address that hits no region gets a single-cycle error response instead.

Each region's base, mask, wait count and enable come in on configuration inputs. Region 0 doubles as the boot select. From reset it decodes a fixed boot window at the slowest timing, so firmware can be fetched before any configuration is written. The block takes one access at a time. Between two accesses it always leaves at least one cycle with every strobe low.

Top module: `csel_ctrl`

## Requirements
- R1: A request sampled while idle whose address `a` satisfies `(a & mask_k) == (base_k & mask_k)` for an enabled region `k` raises `cs[k]` alone from the next cycle, and that bit stays high and unchanged until the acknowledge cycle.
- R2: When several enabled regions match, the region with the lowest index is selected.
- R3: With an effective wait count W, chip-select is high for W+1 consecutive cycles and the acknowledge falls in the last of them. W comes from the region's 5-bit wait field, and field values above 30 are treated as 30.
- R4: The acknowledge is high for exactly one cycle. In the cycle after it, every chip-select, the read strobe and all write strobes are low.
- R5: On a read (`wr`=0), `oe` is high in every chip-select cycle and `we` is all zero.
- R6: On a write, `oe` stays low and `we` (bit i = byte lane i) shows the selected lanes in every chip-select cycle. Size code 0 (byte) selects lane `addr[1:0]`. Code 1 (half) selects lanes 1:0 when `addr[1]`=0 and lanes 3:2 otherwise. Codes 2 (word) and 3 select all four lanes.
- R7: A request that matches no enabled region raises no chip-select, no strobe and no acknowledge. It raises `err` for exactly the one cycle after the request.
- R8: From reset until `cfg_valid[0]` is first seen high, region 0 is enabled with base `BOOT_BASE`, mask `BOOT_MASK` and wait 30, and its configuration inputs are ignored. From then on, region 0 follows its configuration inputs.
- R9: A request presented while an access or error response is in progress, including its acknowledge or error cycle, has no effect.
- R10: During and directly after reset, all chip-selects, `oe`, `we`, `ack`, `err` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one-cycle pulse |
| addr | input | AW | Access address |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Transfer size code |
| cfg_base | input | NREG*AW | Per-region base address, region k at bits k*AW |
| cfg_mask | input | NREG*AW | Per-region address mask |
| cfg_wait | input | NREG*WW | Per-region wait-cycle count |
| cfg_valid | input | NREG | Per-region enable |
| cs | output | NREG | Chip-selects, active high |
| oe | output | 1 | Read strobe |
| we | output | 4 | Byte-lane write strobes |
| ack | output | 1 | Transfer acknowledge |
| err | output | 1 | Unmapped-access response |
| busy | output | 1 | Access or error response in progress |

## Verification
A corrupted wait counter appears at the ports as an acknowledge one or more cycles early or late, measured against the first chip-select cycle. The bench detects it in the access where it happens. A wrong latched selection or lane set shows on the very first strobe cycle as the wrong one-hot chip-select or the wrong write pattern. A sequencer that fails to return to idle shows in the cycle after the acknowledge as lingering strobes, or a later request goes unanswered. A stuck boot flag shows on the first access after region 0 is enabled: either the boot window still answers or the programmed window fails to.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int LANES   = 4;
    localparam int LANE_AW = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DRIVE = 2'd1,
        SEQ_FAULT = 2'd2
    } seq_state_e;

    // Strobe context captured when an access is accepted
    typedef struct packed {
        logic             wr;
        logic [LANES-1:0] lanes;
    } strobe_t;

    // Byte lanes touched by an access of the given size at the given low address
    function automatic logic [LANES-1:0] lane_mask(input logic [LANE_AW-1:0] lo,
                                                   input xfer_size_e sz);
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE: m = LANES'(1) << lo;
            SZ_HALF: m = LANES'(3) << {lo[LANE_AW-1], 1'b0};
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/csel_decode.sv
module csel_decode #(
    parameter int NREG = 12,
    parameter int AW   = 32,
    parameter int IW   = $clog2(NREG)
) (
    input  logic [AW-1:0]      addr,
    input  logic [NREG*AW-1:0] base,
    input  logic [NREG*AW-1:0] mask,
    input  logic [NREG-1:0]    valid,
    output logic               hit,
    output logic [NREG-1:0]    sel,
    output logic [IW-1:0]      idx
);

    logic [NREG-1:0] match;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        logic [AW-1:0] m_g;
        assign m_g      = mask[g*AW +: AW];
        assign match[g] = valid[g] && ((addr & m_g) == (base[g*AW +: AW] & m_g));
    end

    // Lowest index wins: scan downwards so the last assignment is the lowest hit
    always_comb begin
        sel = '0;
        idx = '0;
        hit = |match;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                idx    = IW'(i);
            end
        end
    end

endmodule

// File: rtl/csel_seq.sv
module csel_seq
    import csel_pkg::*;
#(
    parameter int NREG = 12,
    parameter int WW   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             hit,
    input  logic [NREG-1:0]  sel,
    input  logic [WW-1:0]    wait_cyc,
    input  strobe_t          strb_in,
    output logic [NREG-1:0]  cs,
    output logic             oe,
    output logic [LANES-1:0] we,
    output logic             ack,
    output logic             err,
    output logic             busy
);

    seq_state_e      state_q;
    logic [NREG-1:0] sel_q;
    logic [WW-1:0]   cnt_q;
    strobe_t         strb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            sel_q   <= '0;
            cnt_q   <= '0;
            strb_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (req) begin
                        if (hit) begin
                            state_q <= SEQ_DRIVE;
                            sel_q   <= sel;
                            cnt_q   <= wait_cyc;
                            strb_q  <= strb_in;
                        end else begin
                            state_q <= SEQ_FAULT;
                        end
                    end
                end
                SEQ_DRIVE: begin
                    if (cnt_q == '0) begin
                        state_q <= SEQ_IDLE;
                        sel_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    logic driving;
    assign driving = (state_q == SEQ_DRIVE);

    assign cs   = driving ? sel_q : '0;
    assign oe   = driving && !strb_q.wr;
    assign we   = (driving && strb_q.wr) ? strb_q.lanes : '0;
    assign ack  = driving && (cnt_q == '0);
    assign err  = (state_q == SEQ_FAULT);
    assign busy = (state_q != SEQ_IDLE);

endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl
    import csel_pkg::*;
#(
    parameter int          NREG      = 12,
    parameter int          AW        = 32,
    parameter int          WW        = 5,
    parameter int          MAX_WAIT  = 30,
    parameter logic [31:0] BOOT_BASE = 32'hFF00_0000,
    parameter logic [31:0] BOOT_MASK = 32'hFF00_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [AW-1:0]      addr,
    input  logic               wr,
    input  logic [1:0]         size,
    input  logic [NREG*AW-1:0] cfg_base,
    input  logic [NREG*AW-1:0] cfg_mask,
    input  logic [NREG*WW-1:0] cfg_wait,
    input  logic [NREG-1:0]    cfg_valid,
    output logic [NREG-1:0]    cs,
    output logic               oe,
    output logic [3:0]         we,
    output logic               ack,
    output logic               err,
    output logic               busy
);

    localparam int IW = $clog2(NREG);
    localparam logic [WW-1:0] WMAX = WW'(MAX_WAIT);

    // Boot window stays in force until region 0 is first enabled
    logic boot_q;
    always_ff @(posedge clk) begin
        if (rst)               boot_q <= 1'b1;
        else if (cfg_valid[0]) boot_q <= 1'b0;
    end

    logic [NREG*AW-1:0] eff_base, eff_mask;
    logic [NREG*WW-1:0] eff_wait;
    logic [NREG-1:0]    eff_valid;

    for (genvar g = 0; g < NREG; g++) begin : g_eff
        if (g == 0) begin : g_boot
            assign eff_base[AW-1:0] = boot_q ? AW'(BOOT_BASE) : cfg_base[AW-1:0];
            assign eff_mask[AW-1:0] = boot_q ? AW'(BOOT_MASK) : cfg_mask[AW-1:0];
            assign eff_wait[WW-1:0] = boot_q ? WMAX : cfg_wait[WW-1:0];
            assign eff_valid[0]     = boot_q | cfg_valid[0];
        end else begin : g_pass
            assign eff_base[g*AW +: AW] = cfg_base[g*AW +: AW];
            assign eff_mask[g*AW +: AW] = cfg_mask[g*AW +: AW];
            assign eff_wait[g*WW +: WW] = cfg_wait[g*WW +: WW];
            assign eff_valid[g]         = cfg_valid[g];
        end
    end

    logic            hit;
    logic [NREG-1:0] sel;
    logic [IW-1:0]   idx;

    csel_decode #(.NREG(NREG), .AW(AW), .IW(IW)) u_dec (
        .addr  (addr),
        .base  (eff_base),
        .mask  (eff_mask),
        .valid (eff_valid),
        .hit   (hit),
        .sel   (sel),
        .idx   (idx)
    );

    logic [WW-1:0] raw_wait, lim_wait;
    assign raw_wait = eff_wait[idx*WW +: WW];
    assign lim_wait = (raw_wait > WMAX) ? WMAX : raw_wait;

    strobe_t strb;
    assign strb.wr    = wr;
    assign strb.lanes = lane_mask(addr[LANE_AW-1:0], xfer_size_e'(size));

    csel_seq #(.NREG(NREG), .WW(WW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .hit      (hit),
        .sel      (sel),
        .wait_cyc (lim_wait),
        .strb_in  (strb),
        .cs       (cs),
        .oe       (oe),
        .we       (we),
        .ack      (ack),
        .err      (err),
        .busy     (busy)
    );

endmodule

// File: rtl/csel_ctrl_chk.sv
module csel_ctrl_chk #(
    parameter int NREG     = 12,
    parameter int MAX_WAIT = 30
) (
    input logic            clk,
    input logic            rst,
    input logic [NREG-1:0] cs,
    input logic            oe,
    input logic [3:0]      we,
    input logic            ack,
    input logic            err,
    input logic            busy
);

    localparam int RW = $clog2(MAX_WAIT + 2);
    logic [RW-1:0] run_q;

    // Strobe cycles already spent in the current access
    always_ff @(posedge clk) begin
        if (rst)               run_q <= '0;
        else if (|cs && !ack)  run_q <= run_q + 1'b1;
        else                   run_q <= '0;
    end

    a_r1_cs_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(cs));
    a_r1_cs_held:   assert property (@(posedge clk) disable iff (rst)
                        (|cs && !ack) |=> (|cs && $stable(cs)));
    a_r3_wait_cap:  assert property (@(posedge clk) disable iff (rst)
                        |cs |-> (run_q <= RW'(MAX_WAIT)));
    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
    a_r4_gap:       assert property (@(posedge clk) disable iff (rst)
                        ack |=> (cs == '0 && !oe && we == '0));
    a_r4_ack_cs:    assert property (@(posedge clk) disable iff (rst) ack |-> |cs);
    a_r5_oe_we_excl:assert property (@(posedge clk) disable iff (rst) oe |-> (we == '0 && |cs));
    a_r6_we_cs:     assert property (@(posedge clk) disable iff (rst) (we != '0) |-> |cs);
    a_r7_err_quiet: assert property (@(posedge clk) disable iff (rst)
                        err |-> (cs == '0 && !ack && !oe && we == '0));
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst) err |=> !err);
    a_r9_busy:      assert property (@(posedge clk) disable iff (rst) (|cs || err) |-> busy);

endmodule

bind csel_ctrl csel_ctrl_chk #(.NREG(NREG), .MAX_WAIT(MAX_WAIT)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .cs   (cs),
    .oe   (oe),
    .we   (we),
    .ack  (ack),
    .err  (err),
    .busy (busy)
);

// File: tb/csel_ctrl_test.sv
module csel_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 12;
    localparam int AW   = 32;
    localparam int WW   = 5;
    localparam int NONE = 15;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req = 1'b0;
    logic [AW-1:0]      addr = '0;
    logic               wr = 1'b0;
    logic [1:0]         size = 2'd0;
    logic [NREG*AW-1:0] cfg_base;
    logic [NREG*AW-1:0] cfg_mask;
    logic [NREG*WW-1:0] cfg_wait;
    logic [NREG-1:0]    cfg_valid;
    logic [NREG-1:0]    cs;
    logic               oe;
    logic [3:0]         we;
    logic               ack, err, busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    csel_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .wr(wr), .size(size),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_wait(cfg_wait),
        .cfg_valid(cfg_valid), .cs(cs), .oe(oe), .we(we), .ack(ack),
        .err(err), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int exp_wait [NREG];
    bit boot_on  = 1'b1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected write lanes, from R6
    function automatic logic [3:0] lanes_of(input logic [31:0] a, input logic [1:0] sz);
        case (sz)
            2'd0: case (a[1:0])
                      2'd0: return 4'b0001;
                      2'd1: return 4'b0010;
                      2'd2: return 4'b0100;
                      default: return 4'b1000;
                  endcase
            2'd1: return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One access; exp_reg == NONE means an error response is expected
    task automatic access(input logic [31:0] a, input logic w, input logic [1:0] sz,
                          input int exp_reg);
        int n;
        bit bad_cs, bad_oe, bad_we;
        logic [3:0] lw;
        int ew;
        lw = w ? lanes_of(a, sz) : 4'b0000;
        @(negedge clk);
        req = 1'b1; addr = a; wr = w; size = sz;
        @(negedge clk);
        req = 1'b0;
        if (exp_reg == NONE) begin
            check(err && cs == '0 && !ack && !oe && we == '0, "R7 error cycle",
                  {19'd0, err, cs}, 32'h1000);
            @(negedge clk);
            check(!err && cs == '0 && !ack, "R7 error single",
                  {19'd0, err, cs}, 32'h0);
        end else begin
            ew = (exp_reg == 0 && boot_on) ? 30 : exp_wait[exp_reg];
            n = 0; bad_cs = 0; bad_oe = 0; bad_we = 0;
            while (n < 40) begin
                if (cs != NREG'(1) << exp_reg) bad_cs = 1;
                if (oe != !w) bad_oe = 1;
                if (we != lw) bad_we = 1;
                if (ack) break;
                n++;
                @(negedge clk);
            end
            check(!bad_cs, "R1/R2 chip-select", 32'(cs), 32'(NREG'(1) << exp_reg));
            check(n == ew, "R3 ack delay", n, ew);
            if (w) check(!bad_we && !bad_oe, "R6 write strobes", {27'd0, oe, we}, {28'd0, lw});
            else   check(!bad_oe && !bad_we, "R5 read strobes", {27'd0, oe, we}, 32'h10);
            @(negedge clk);
            check(cs == '0 && !oe && we == '0 && !ack, "R4 idle gap",
                  {15'd0, ack, oe, we, cs}, 32'h0);
        end
    endtask

    // addr[38:7] wr[6] size[5:4] exp_region[3:0]
    localparam logic [38:0] VEC [14] = '{
        {32'h0100_0000, 1'b0, 2'd2, 4'd1},
        {32'h0200_0003, 1'b1, 2'd0, 4'd2},
        {32'h0300_0002, 1'b1, 2'd1, 4'd3},
        {32'h0400_0001, 1'b1, 2'd1, 4'd4},
        {32'h0500_0000, 1'b1, 2'd2, 4'd5},
        {32'h0600_0002, 1'b1, 2'd0, 4'd6},
        {32'h0800_0000, 1'b0, 2'd2, 4'd8},
        {32'h0800_0001, 1'b1, 2'd0, 4'd8},
        {32'h0900_0000, 1'b1, 2'd3, 4'd9},
        {32'h0A00_0000, 1'b0, 2'd2, 4'd10},
        {32'h0B00_0000, 1'b0, 2'd2, 4'd15},
        {32'h0C00_0000, 1'b1, 2'd2, 4'd15},
        {32'h0000_0010, 1'b1, 2'd2, 4'd0},
        {32'h0210_0000, 1'b0, 2'd2, 4'd2}
    };

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        // Configuration: region k at k<<24 with wait k, with exceptions
        for (int k = 0; k < NREG; k++) begin
            cfg_base[k*AW +: AW] = 32'(k) << 24;
            cfg_mask[k*AW +: AW] = 32'hFF00_0000;
            cfg_wait[k*WW +: WW] = 5'(k);
            exp_wait[k] = k;
        end
        cfg_wait[0 +: WW] = 5'd2;          exp_wait[0] = 2;
        cfg_base[7*AW +: AW] = 32'h0200_0000;
        cfg_mask[7*AW +: AW] = 32'hFE00_0000;   // overlaps regions 2 and 3
        cfg_wait[8*WW +: WW] = 5'd0;       exp_wait[8] = 0;
        cfg_wait[10*WW +: WW] = 5'd31;     exp_wait[10] = 30;  // R3 clamp
        cfg_valid = 12'b0111_1111_1110;     // region 0 disabled, region 11 disabled

        repeat (3) @(negedge clk);
        check(cs == '0 && !oe && we == '0 && !ack && !err && !busy, "R10 in reset",
              {14'd0, busy, err, ack, oe, cs}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(cs == '0 && !oe && we == '0 && !ack && !err && !busy, "R10 after reset",
              {14'd0, busy, err, ack, oe, cs}, 32'h0);

        // R8: boot window live, region 0 inputs ignored
        access(32'hFF00_0010, 1'b0, 2'd2, 0);
        access(32'h0000_0004, 1'b0, 2'd2, NONE);

        // R8: enable region 0, boot window gone
        @(negedge clk);
        cfg_valid[0] = 1'b1;
        boot_on = 1'b0;
        @(negedge clk);
        access(32'hFF00_0010, 1'b0, 2'd2, NONE);
        access(32'h0000_0004, 1'b0, 2'd2, 0);

        // Table walk: R1 R2 R3 R5 R6 R7
        for (int v = 0; v < 14; v++) begin
            access(VEC[v][38:7], VEC[v][6], VEC[v][5:4], int'(VEC[v][3:0]));
        end

        // R8: dropping region 0 enable later does not restore boot window
        @(negedge clk);
        cfg_valid[0] = 1'b0;
        access(32'hFF00_0000, 1'b0, 2'd2, NONE);

        // R9: requests during an access and during its ack cycle are ignored
        begin
            int n;
            bit bad;
            @(negedge clk);
            req = 1'b1; addr = 32'h0500_0000; wr = 1'b0; size = 2'd2;
            @(negedge clk);
            addr = 32'h0100_0000; wr = 1'b1;   // held high throughout
            n = 0; bad = 0;
            while (n < 40 && !ack) begin
                if (cs != 12'h020) bad = 1;
                n++;
                @(negedge clk);
            end
            if (cs != 12'h020) bad = 1;
            req = 1'b0;
            check(!bad && n == 5, "R9 access undisturbed", n, 5);
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(cs == '0 && !err && !busy, "R9 no late access",
                      {18'd0, busy, err, cs}, 32'h0);
            end
        end

        // R9: request during an error cycle is ignored
        @(negedge clk);
        req = 1'b1; addr = 32'h0C00_0000;
        @(negedge clk);
        addr = 32'h0100_0000;
        check(err == 1'b1, "R7 error seen", {31'd0, err}, 1);
        @(negedge clk);
        req = 1'b0;
        check(cs == '0 && !busy, "R9 ignored in error cycle", {19'd0, busy, cs}, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule